// File: doc/BRIEF.md
# PCM Serial Output Formatter

This block turns a stream of stereo PCM sample pairs into a three-wire serial audio output. The three wires are a bit clock, a channel-select clock and a data line. The bit clock is made by dividing the system clock. Each channel occupies one slot of 16 or 32 bit clocks: the left slot has the channel select low and the right slot has it high. The word carried in a slot is 16, 18, 20 or 24 bits long. It is sent either most significant bit first or least significant bit first. In a 32-cycle slot the word can be placed at the start of the slot or at the end, and every cycle the word does not fill carries a zero.

Samples arrive on a valid/ready input and are taken only at the start of a left slot. `s_ready` is high for exactly one system cycle: the cycle just before the bit-clock falling edge that opens a left slot. A pair is transferred when `s_valid` and `s_ready` are both high in that cycle. The producer may hold `s_valid` high for as long as it likes, and the pair waits until the next frame start. If `s_valid` is low in the `s_ready` cycle, the previous pair is sent again and `underrun` is raised for that frame. Configuration pins may change at any time. They are captured at the same frame boundary as the samples, so a frame is never sent with a mix of settings.

Top module: `pcm_serializer`

## Requirements
- R1: `bclk` has a period of exactly 2*H system cycles with equal high and low phases, where H is the `cfg_half` value captured at the most recent left-slot start; a value of 0 is treated as 1.
- R2: `lrclk` is low during left slots and high during right slots. `lrclk` and `sdata` change only in the system cycle in which `bclk` falls.
- R3: A channel slot lasts 32 bit clocks when `cfg_slot32` is 1 and 16 bit clocks when it is 0.
- R4: `cfg_prec` selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The sample occupies bits [length-1:0] of `s_left`/`s_right`, and higher input bits are ignored.
- R5: With `cfg_lsb_first` = 0 the word is sent most significant bit first; with 1 it is sent least significant bit first.
- R6: In a 32-cycle slot, `cfg_right_just` = 0 puts the word in the first cycles of the slot and 1 puts it in the last cycles. In a 16-cycle slot this setting has no effect.
- R7: Slot cycles that carry no word bit drive `sdata` = 0.
- R8: In a 16-cycle slot, a word longer than 16 bits is cut to its upper 16 bits.
- R9: `s_ready` is high for exactly one system cycle per frame, and the next `bclk` falling edge opens a left slot. That frame carries the pair taken in that cycle.
- R10: If `s_valid` is low in the `s_ready` cycle, the frame repeats the previous pair and `underrun` is 1 from that frame start until the next one. Otherwise `underrun` is 0 for the frame.
- R11: All configuration inputs are captured only at a left-slot start. Changes made during a frame do not affect that frame.
- R12: While reset is held, `bclk` = 1, `lrclk` = 1, `sdata` = 0 and `underrun` = 0. The first `bclk` falling edge after reset opens a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_half | input | HALF_W | Bit-clock half period in system cycles |
| cfg_prec | input | 2 | Word length code |
| cfg_lsb_first | input | 1 | 1 sends the least significant bit first |
| cfg_slot32 | input | 1 | 1 selects 32-cycle slots, 0 selects 16-cycle slots |
| cfg_right_just | input | 1 | 1 places the word at the end of a 32-cycle slot |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | The pair is taken in this cycle |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Channel select, low for left |
| sdata | output | 1 | Serial data, changes on the falling edge of `bclk` |
| underrun | output | 1 | The current frame repeats the previous pair |

## Verification
A wrong slot position or channel bit shows up at the next rising edge of `bclk`. The symptom is a data bit in the wrong place, or a slot whose length is not 16 or 32. A frame boundary that is lost or doubled shows up within one frame, as a missing or extra `s_ready` pulse or as a wrong `underrun` level. A divider that counts wrongly changes the measured bit-clock period on the next rising edge. Configuration captured in the wrong place only shows when the settings change partway through a frame, and it then corrupts that frame's data. The bench therefore changes the settings while frames are running.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

  typedef enum logic [1:0] {
    PREC_16 = 2'd0,
    PREC_18 = 2'd1,
    PREC_20 = 2'd2,
    PREC_24 = 2'd3
  } prec_e;

  typedef struct packed {
    prec_e prec;
    logic  lsb_first;
    logic  slot32;
    logic  right_just;
  } fmt_t;

  function automatic logic [5:0] prec_bits(prec_e p);
    case (p)
      PREC_16: prec_bits = 6'd16;
      PREC_18: prec_bits = 6'd18;
      PREC_20: prec_bits = 6'd20;
      default: prec_bits = 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/pcm_clk_div.sv
module pcm_clk_div #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_i,
  input  logic              load_i,
  output logic              bclk_o,
  output logic              fall_o
);
  logic [HALF_W-1:0] half_act;
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;

  assign lim    = (half_act == '0) ? '0 : half_act - 1'b1;
  assign fall_o = bclk_o && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bclk_o   <= 1'b1;
      half_act <= HALF_W'(1);
    end else begin
      if (cnt == lim) begin
        cnt    <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (load_i) half_act <= half_i;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

  p_load_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> fall_o);

endmodule

// File: rtl/pcm_slot_ctr.sv
module pcm_slot_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       slot32_i,
  output logic       chan_o,
  output logic       frame_start_o,
  output logic [4:0] nxt_pos_o,
  output logic       nxt_chan_o
);
  logic [4:0] pos;
  logic       at_last;

  assign at_last       = (pos == (slot32_i ? 5'd31 : 5'd15));
  assign frame_start_o = fall_i && at_last && chan_o;
  assign nxt_pos_o     = at_last ? 5'd0 : pos + 5'd1;
  assign nxt_chan_o    = at_last ? ~chan_o : chan_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= 5'd31;
      chan_o <= 1'b1;
    end else if (fall_i) begin
      pos    <= nxt_pos_o;
      chan_o <= nxt_chan_o;
    end
  end

  p_short_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot32_i |-> pos < 5'd16);

endmodule

// File: rtl/pcm_bit_pick.sv
module pcm_bit_pick
  import pcm_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [4:0]          pos_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  fmt_t                fmt_i,
  output logic                bit_o
);
  logic [5:0] pw, w, shift, off, p, j, idx, sel;
  logic [SAMPLE_W-1:0] shifted;
  logic in_word;

  always_comb begin
    pw      = prec_bits(fmt_i.prec);
    w       = fmt_i.slot32 ? pw : 6'd16;
    shift   = pw - w;
    off     = (fmt_i.slot32 && fmt_i.right_just) ? 6'd32 - w : 6'd0;
    p       = {1'b0, pos_i};
    in_word = (p >= off) && (p < off + w);
    j       = p - off;
    idx     = fmt_i.lsb_first ? j : w - 6'd1 - j;
    sel     = shift + idx;
    shifted = word_i >> sel;
    bit_o   = in_word && shifted[0];
  end

endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
  import pcm_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [1:0]          cfg_prec,
  input  logic                cfg_lsb_first,
  input  logic                cfg_slot32,
  input  logic                cfg_right_just,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                underrun
);
  fmt_t fmt_act, fmt_in, fmt_eff;
  logic [SAMPLE_W-1:0] left_q, right_q, left_eff, right_eff, word_eff;
  logic       fall, frame_start, nxt_chan, nxt_bit;
  logic [4:0] nxt_pos;

  assign fmt_in = '{prec: prec_e'(cfg_prec), lsb_first: cfg_lsb_first,
                    slot32: cfg_slot32, right_just: cfg_right_just};

  pcm_clk_div #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .half_i(cfg_half), .load_i(frame_start),
    .bclk_o(bclk), .fall_o(fall));

  pcm_slot_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .slot32_i(fmt_act.slot32),
    .chan_o(lrclk), .frame_start_o(frame_start),
    .nxt_pos_o(nxt_pos), .nxt_chan_o(nxt_chan));

  assign s_ready   = frame_start;
  assign fmt_eff   = frame_start ? fmt_in : fmt_act;
  assign left_eff  = (frame_start && s_valid) ? s_left  : left_q;
  assign right_eff = (frame_start && s_valid) ? s_right : right_q;
  assign word_eff  = nxt_chan ? right_eff : left_eff;

  pcm_bit_pick #(.SAMPLE_W(SAMPLE_W)) u_pick (
    .pos_i(nxt_pos), .word_i(word_eff), .fmt_i(fmt_eff), .bit_o(nxt_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act  <= '{prec: PREC_24, lsb_first: 1'b0, slot32: 1'b1, right_just: 1'b0};
      left_q   <= '0;
      right_q  <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (frame_start) begin
        fmt_act  <= fmt_in;
        left_q   <= left_eff;
        right_q  <= right_eff;
        underrun <= !s_valid;
      end
      if (fall) sdata <= nxt_bit;
    end
  end

  p_sdata_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));

  p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(bclk));

  p_ready_opens_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> (!lrclk && $fell(bclk)));

  p_underrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun);

  p_underrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> $stable(underrun));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> $stable(fmt_act));

endmodule

// File: tb/pcm_serializer_bench.sv
module pcm_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NFR = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd1;
  logic [1:0]  cfg_prec = 2'd3;
  logic        cfg_lsb_first = 1'b0, cfg_slot32 = 1'b1, cfg_right_just = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_left = '0, s_right = '0;
  logic        bclk, lrclk, sdata, underrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serializer u_pcm_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_prec(cfg_prec),
    .cfg_lsb_first(cfg_lsb_first), .cfg_slot32(cfg_slot32),
    .cfg_right_just(cfg_right_just), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .underrun(underrun));

  typedef struct {
    logic [23:0] l, r;
    logic [1:0]  prec;
    bit lsb, s32, rj, und;
    int period;
  } frm_t;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(int p, bit ch, frm_t f);
    int pw, w, off, j;
    logic [31:0] v;
    pw = (f.prec == 0) ? 16 : (f.prec == 1) ? 18 : (f.prec == 2) ? 20 : 24;
    w  = f.s32 ? pw : 16;
    off = (f.s32 && f.rj) ? 32 - w : 0;
    v = {8'h0, ch ? f.r : f.l} & ((32'd1 << pw) - 1);
    if (w < pw) v = v >> (pw - 16);
    if (p < off || p >= off + w) return 1'b0;
    j = p - off;
    return f.lsb ? v[j] : v[w - 1 - j];
  endfunction

  // monitor
  frm_t cur, pend;
  logic [23:0] last_l = '0, last_r = '0;
  bit started = 0, prev_bclk = 1, cur_lr = 0;
  int per_cnt = 0, slot_bits = 0, slot_err = 0, per_err = 0, ready_cnt = 0, frames = 0;

  task automatic end_slot();
    check(slot_bits == (cur.s32 ? 32 : 16), "R3 slot length", slot_bits, cur.s32 ? 32 : 16);
    check(slot_err == 0, "R4 R5 R6 R7 R8 R11 slot data", slot_err, 0);
    check(per_err == 0, "R1 bclk period", per_err, 0);
    if (!cur_lr) begin
      check(underrun == cur.und, "R10 underrun", underrun, cur.und);
      check(ready_cnt == 1, "R9 one ready per frame", ready_cnt, 1);
      ready_cnt = 0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_bclk = bclk;
    end else if (!finished) begin
      per_cnt++;
      if (s_ready) begin
        ready_cnt++;
        pend.prec = cfg_prec; pend.lsb = cfg_lsb_first;
        pend.s32 = cfg_slot32; pend.rj = cfg_right_just;
        pend.period = 2 * ((cfg_half == 0) ? 1 : int'(cfg_half));
        pend.und = !s_valid;
        if (s_valid) begin last_l = s_left; last_r = s_right; end
        pend.l = last_l; pend.r = last_r;
      end
      if (bclk && !prev_bclk) begin
        if (!started) begin
          started = 1;
          check(lrclk == 1'b0, "R12 first slot is left", lrclk, 0);
          cur = pend; cur_lr = 0; slot_bits = 0; slot_err = 0; per_err = 0;
        end else if (lrclk != cur_lr) begin
          end_slot();
          if (!lrclk) begin cur = pend; frames++; end
          cur_lr = lrclk; slot_bits = 0; slot_err = 0; per_err = 0;
        end else if (per_cnt != cur.period) begin
          per_err++;
        end
        if (sdata !== exp_bit(slot_bits, lrclk, cur)) slot_err++;
        slot_bits++;
        per_cnt = 0;
      end
      prev_bclk = bclk;
    end
  end

  task automatic set_cfg(int k);
    case (k)
      0: begin cfg_prec = 3; cfg_slot32 = 1; cfg_right_just = 0; cfg_lsb_first = 0; cfg_half = 1; end
      1: begin cfg_prec = 3; cfg_slot32 = 1; cfg_right_just = 1; cfg_lsb_first = 1; cfg_half = 2; end
      2: begin cfg_prec = 0; cfg_slot32 = 0; cfg_right_just = 1; cfg_lsb_first = 0; cfg_half = 1; end
      3: begin cfg_prec = 3; cfg_slot32 = 0; cfg_right_just = 0; cfg_lsb_first = 1; cfg_half = 3; end
      4: begin cfg_prec = 1; cfg_slot32 = 1; cfg_right_just = 1; cfg_lsb_first = 0; cfg_half = 1; end
      5: begin cfg_prec = 2; cfg_slot32 = 1; cfg_right_just = 0; cfg_lsb_first = 1; cfg_half = 0; end
      6: begin cfg_prec = 0; cfg_slot32 = 1; cfg_right_just = 1; cfg_lsb_first = 1; cfg_half = 2; end
      7: begin cfg_prec = 2; cfg_slot32 = 0; cfg_right_just = 0; cfg_lsb_first = 0; cfg_half = 1; end
      default: begin
        cfg_prec = 2'($urandom % 4); cfg_slot32 = 1'($urandom);
        cfg_right_just = 1'($urandom); cfg_lsb_first = 1'($urandom);
        cfg_half = 8'($urandom % 4);
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    s_valid = 1; s_left = 24'hA5C3F1; s_right = 24'h3C0F96;
    repeat (3) @(negedge clk);
    check(bclk == 1 && lrclk == 1 && sdata == 0 && underrun == 0,
          "R12 reset state", {bclk, lrclk, sdata, underrun}, 4'b1100);
    @(posedge clk); #1 rst_n = 1;
    for (int k = 0; k < NFR; k++) begin
      bit skip = (k % 9 == 6) || ($urandom % 8 == 0);
      if (k > 0) begin
        if (skip) s_valid = 0;
        else begin
          s_valid = 1;
          s_left  = (k == 3) ? 24'hFFFFFF : 24'($urandom);
          s_right = (k == 3) ? 24'h000001 : 24'($urandom);
        end
      end
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1 s_valid = 0;
      if (k < 8 || $urandom % 3 == 0) begin
        repeat ($urandom % 40) @(posedge clk);
        #1 set_cfg(k + 1 < 8 ? k + 1 : 99);
      end
    end
    while (frames < NFR) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", frames, NFR);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule